// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers event pulses from a parameterised set of request lines into a sticky status word. A mask word selects which latched events may drive a single interrupt line to the processor. A separate summary line reports whether any event is latched at all, whatever the mask holds.

Software reaches the two words through a single-cycle 32-bit register port. The port has an address, a read strobe, a write enable, write data and registered read data. To acknowledge events, software writes to the status word, and the written value is ANDed into it. A zero bit therefore clears its event and a one bit keeps it. Request lines are sampled and rising-edge detected, so a held level latches only once.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, status and mask are zero, and both `cpu_irq` and `any_pend` are low.
- R2: A rising edge on `req[n]` sets status bit n on the next clock. A set bit stays set while `req[n]` is held high, and it stays set after `req[n]` falls.
- R3: A write to address 0x00 sets status to the old status ANDed with the write data, limited to the low NUM_REQ bits.
- R4: A write to address 0x04 stores the low NUM_REQ bits of the write data into the mask. The mask bits at NUM_REQ and above read back as zero.
- R5: A read strobe to address 0x00 returns status, and a read strobe to address 0x04 returns the mask, on `rdata` one clock later. Unused high bits read as zero.
- R6: A read strobe to any other address returns 0xFFFFFFFF one clock later. A write to any other address changes neither status nor mask.
- R7: `cpu_irq` is registered. It is high in the cycle after the cycle in which (status AND mask) is nonzero.
- R8: `any_pend` is high exactly while status is nonzero, whatever the mask holds.
- R9: If a request edge on bit n and a status write that clears bit n fall in the same cycle, bit n ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_REQ | Event request lines, rising-edge detected |
| addr | input | 32 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid one clock after `rd_en` |
| cpu_irq | output | 1 | Masked interrupt to the processor, registered |
| any_pend | output | 1 | High when any status bit is set |

## Verification
The functions that can fall in the same cycle are request latching and acknowledge. A request edge can arrive in the same clock as a status write that clears the same bit, or a different bit. The bench provokes this by driving a `req` rising edge together with a write of zeros to address 0x00. It then reads status back and compares it bit by bit against a reference model, which applies the rule that the request wins. The same model follows `cpu_irq` and `rdata` on every clock, so that any misordering of the two updates shows up at the ports.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int NUM_REQ = 11,
  parameter logic [31:0] STAT_ADDR = 32'h0,
  parameter logic [31:0] MASK_ADDR = 32'h4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  input  logic [31:0]        addr,
  input  logic               wr_en,
  input  logic [31:0]        wdata,
  input  logic               rd_en,
  output logic [31:0]        rdata,
  output logic               cpu_irq,
  output logic               any_pend
);
  localparam int PAD = 32 - NUM_REQ;

  logic [NUM_REQ-1:0] stat_q, mask_q, req_q, rise;
  logic stat_hit, mask_hit;

  assign rise     = req & ~req_q;
  assign stat_hit = (addr == STAT_ADDR);
  assign mask_hit = (addr == MASK_ADDR);
  assign any_pend = |stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      req_q <= req;
      if (wr_en && stat_hit) stat_q <= (stat_q & wdata[NUM_REQ-1:0]) | rise;
      else                   stat_q <= stat_q | rise;
      if (wr_en && mask_hit) mask_q <= wdata[NUM_REQ-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_irq <= 1'b0;
      rdata   <= '0;
    end else begin
      cpu_irq <= |(stat_q & mask_q);
      if (rd_en) begin
        if (stat_hit)      rdata <= {{PAD{1'b0}}, stat_q};
        else if (mask_hit) rdata <= {{PAD{1'b0}}, mask_q};
        else               rdata <= '1;
      end
    end
  end

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && stat_hit) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R6
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stat_hit && !mask_hit) |=> $stable(mask_q));
  // R7
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & mask_q)) |=> cpu_irq);
  // R8
  pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend == (stat_q != '0));
  // R9
  req_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((stat_q & $past(rise)) == $past(rise)));
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam int N = 11;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0;
  logic [31:0] addr = '0, wdata = '0, rdata;
  logic wr_en = 0, rd_en = 0, cpu_irq, any_pend;
  int checks = 0, fails = 0, cyc = 0;

  irq_status_ctrl #(.NUM_REQ(N)) dut (.*);
  always #2.5 clk = ~clk;

  // reference model state
  logic [N-1:0] m_stat = '0, m_mask = '0, m_req = '0;
  logic [31:0] m_rdata = '0;
  logic m_irq = 0;

  always @(posedge clk) begin
    logic [N-1:0] r;
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_stat = '0; m_mask = '0; m_req = '0; m_rdata = '0; m_irq = 0;
    end else begin
      r = req & ~m_req;
      m_irq = (m_stat & m_mask) != 0;
      if (rd_en) m_rdata = (addr == 0) ? 32'(m_stat) : (addr == 4) ? 32'(m_mask) : 32'hFFFF_FFFF;
      if (wr_en && addr == 4) m_mask = wdata[N-1:0];
      if (wr_en && addr == 0) m_stat = (m_stat & wdata[N-1:0]) | r;
      else m_stat = m_stat | r;
      m_req = req;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison (R7, R8)
  always @(negedge clk) if (rst_n) begin
    chk("R7 cpu_irq", 32'(cpu_irq), 32'(m_irq));
    chk("R8 any_pend", 32'(any_pend), 32'(m_stat != 0));
    chk("R5 rdata", rdata, m_rdata);
  end

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(logic [31:0] a, string tag, logic [31:0] exp);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk(tag, rdata, exp);
  endtask
  task automatic pulse(logic [N-1:0] v);
    @(negedge clk); req = v;
    @(negedge clk); req = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq reset", 32'(cpu_irq), 0);
    chk("R1 pend reset", 32'(any_pend), 0);
    rst_n = 1;
    rd(0, "R1 status reset", 0);
    rd(4, "R1 mask reset", 0);
    pulse(11'h005);
    rd(0, "R2 latch", 32'h005);
    chk("R8 pend masked", 32'(any_pend), 1);
    chk("R7 no irq while masked", 32'(cpu_irq), 0);
    @(negedge clk); req = 11'h400;
    repeat (3) @(negedge clk);
    rd(0, "R2 held level", 32'h405);
    req = '0;
    rd(0, "R2 after fall", 32'h405);
    wr(4, 32'hFFFF_FFFF);
    rd(4, "R4 mask high bits", 32'h7FF);
    @(negedge clk);
    chk("R7 irq on", 32'(cpu_irq), 1);
    wr(0, 32'hFFFF_FFFB);
    rd(0, "R3 ack one bit", 32'h401);
    wr(8, 32'h0);
    rd(0, "R6 write ignored status", 32'h401);
    rd(4, "R6 write ignored mask", 32'h7FF);
    rd(8, "R6 unmapped read", 32'hFFFF_FFFF);
    rd(32'h100, "R6 unmapped read far", 32'hFFFF_FFFF);
    @(negedge clk); req = 11'h002; addr = 0; wdata = 0; wr_en = 1;
    @(negedge clk); wr_en = 0; req = '0;
    rd(0, "R9 request wins", 32'h002);
    wr(4, 32'h0);
    @(negedge clk); @(negedge clk);
    chk("R7 irq off after mask", 32'(cpu_irq), 0);
    wr(0, 0);
    rd(0, "R3 clear all", 0);
    chk("R8 pend clear", 32'(any_pend), 0);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 5000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule